// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns queued characters into asynchronous serial frames. Characters arrive on a byte-wide port with a valid/ready handshake and wait in a small internal queue. The transmitter takes the next character from that queue only on a pulse of the external bit-rate enable, and only while it is switched on and no break is being forced. It then drives a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Each bit lasts exactly one bit-rate enable period.

Three packed fields set the frame layout: character length, parity type and stop-bit count. The block reads these fields once, at the start of each frame, so a change of format never corrupts a frame already on the line. Software controls the line with pulse inputs: one pair switches the transmitter on and off, and another pair starts and ends a break, during which the line is held low. Two status outputs are provided. One shows that a frame is being shifted out. The other shows that no characters remain queued.

Top module: `uart_frame_tx`

## Requirements
- R1: The length field `fmt_len` selects the number of data bits: 11 gives 6, 10 gives 7, and 00 or 01 give 8. Only the low bits of `in_data` that the selected length covers are sent.
- R2: The parity field `fmt_par` is decoded as follows. 000 sends a bit that makes the count of ones in the data plus parity even. 001 makes that count odd. 010 sends a constant 0. 011 sends a constant 1. Any value with bit 2 set sends no parity bit.
- R3: The stop field `fmt_stop` selects the number of high stop bits: 00 gives one, and any other value gives two.
- R4: The line idles high. A frame is a single low start bit followed by the data bits, least significant first, then the parity bit and the stop bits. Each bit lasts one period of `bit_tick`, and a frame begins on the clock edge where `bit_tick` is high.
- R5: The transmitter is off after reset. A pulse on `ctl_en` turns it on and a pulse on `ctl_dis` turns it off. While it is off, no new frame starts and queued characters stay queued.
- R6: When `ctl_en` and `ctl_dis` are high in the same cycle, the transmitter ends up off.
- R7: A pulse on `ctl_brk_on` holds `txd` low from the next cycle on, and no frame starts while the break lasts. A pulse on `ctl_brk_off` returns the line high. If both pulses come in the same cycle, the break is not entered.
- R8: The format fields are sampled when a frame starts. A change during the frame does not affect that frame.
- R9: `tx_active` is high from the start bit through the last stop bit. `tx_empty` is high exactly when the queue holds no character.
- R10: The queue holds `QDEPTH` characters in arrival order. `in_ready` is low while the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | DATA_W | Character to queue |
| in_valid | input | 1 | Character on `in_data` is offered |
| in_ready | output | 1 | Queue can accept a character |
| fmt_len | input | 2 | Character length code |
| fmt_par | input | 3 | Parity type code |
| fmt_stop | input | 2 | Stop-bit count code |
| ctl_en | input | 1 | Pulse: turn transmitter on |
| ctl_dis | input | 1 | Pulse: turn transmitter off (wins over on) |
| ctl_brk_on | input | 1 | Pulse: begin break |
| ctl_brk_off | input | 1 | Pulse: end break (wins over begin) |
| bit_tick | input | 1 | One-cycle bit-rate enable |
| txd | output | 1 | Serial line |
| tx_active | output | 1 | A frame is being shifted out |
| tx_empty | output | 1 | Queue holds no character |

## Verification
A wrong bit counter or latched format shows up on `txd` inside the same frame. The decoded character or parity bit is wrong, or a missing second stop bit lets the start bit of the next queued character arrive early. These faults appear within one frame time of the fault. A wrong on/off or break state shows up within one bit period as a start bit that should not be there, or as a queued character that never leaves. The bench pairs every decoded frame with the format that was in force when its character was pushed. A format that the block latched at the wrong moment therefore fails on the very frame concerned.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;

   // Character length codes (two-bit field).
   localparam logic [1:0] LEN_CODE_7 = 2'b10;
   localparam logic [1:0] LEN_CODE_6 = 2'b11;

   // Parity codes (three-bit field); bit 2 set means no parity bit.
   localparam logic [1:0] PAR_EVEN  = 2'b00;
   localparam logic [1:0] PAR_ODD   = 2'b01;
   localparam logic [1:0] PAR_ZERO  = 2'b10;
   localparam logic [1:0] PAR_ONE   = 2'b11;

   function automatic int unsigned data_bits(input logic [1:0] len);
      case (len)
         LEN_CODE_6: return 6;
         LEN_CODE_7: return 7;
         default:    return 8;
      endcase
   endfunction

endpackage

// File: rtl/uart_ftx_queue.sv
module uart_ftx_queue #(
   parameter int DATA_W = 8,
   parameter int QDEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              full,
   output logic              empty
);
   localparam int CNT_W = $clog2(QDEPTH + 1);

   logic [CNT_W-1:0] count_q;

   assign full  = (count_q == CNT_W'(QDEPTH));
   assign empty = (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (push && !pop)
         count_q <= count_q + 1'b1;
      else if (pop && !push)
         count_q <= count_q - 1'b1;
   end

   generate
      if (QDEPTH == 1) begin : g_single
         logic [DATA_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q <= '0;
            else if (push)
               slot_q <= push_data;
         end
         assign head = slot_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(QDEPTH);
         logic [DATA_W-1:0] mem_q [QDEPTH];
         logic [PTR_W-1:0]  wr_q, rd_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_q <= '0;
               rd_q <= '0;
               for (int i = 0; i < QDEPTH; i++) mem_q[i] <= '0;
            end else begin
               if (push) begin
                  mem_q[wr_q] <= push_data;
                  wr_q <= (wr_q == PTR_W'(QDEPTH - 1)) ? '0 : wr_q + 1'b1;
               end
               if (pop)
                  rd_q <= (rd_q == PTR_W'(QDEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
         end
         assign head = mem_q[rd_q];
      end
   endgenerate

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);                                   // R10
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> !full || $stable(count_q));     // R10

endmodule

// File: rtl/uart_ftx_ctrl.sv
module uart_ftx_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_en,
   input  logic ctl_dis,
   input  logic ctl_brk_on,
   input  logic ctl_brk_off,
   output logic tx_on,
   output logic brk_act
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_on   <= 1'b0;
         brk_act <= 1'b0;
      end else begin
         if (ctl_dis)
            tx_on <= 1'b0;
         else if (ctl_en)
            tx_on <= 1'b1;
         if (ctl_brk_off)
            brk_act <= 1'b0;
         else if (ctl_brk_on)
            brk_act <= 1'b1;
      end
   end

   AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && ctl_dis) |=> !tx_on);                   // R6
   AST_BRK_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_brk_off |=> !brk_act);                         // R7

endmodule

// File: rtl/uart_ftx_shift.sv
module uart_ftx_shift
   import uart_ftx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_on,
   input  logic              brk_act,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_head,
   input  logic [1:0]        fmt_len,
   input  logic [2:0]        fmt_par,
   input  logic [1:0]        fmt_stop,
   output logic              pop,
   output logic              busy,
   output logic              line
);
   // Bits after the start bit: data, parity, two stops at most.
   localparam int BODY_W = DATA_W + 3;
   localparam int CNT_W  = $clog2(BODY_W + 1);

   logic [BODY_W-1:0] body;
   logic [CNT_W-1:0]  body_len;
   logic [BODY_W-1:0] sh_q;
   logic [CNT_W-1:0]  left_q;
   logic              start;

   always_comb begin
      int unsigned nd;
      int unsigned pos;
      logic        par_bit;
      logic        has_par;
      logic [DATA_W-1:0] masked;
      nd      = data_bits(fmt_len);
      masked  = '0;
      body    = '1;
      pos     = 0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(nd)) begin
            masked[i] = q_head[i];
            body[pos] = q_head[i];
            pos       = pos + 1;
         end
      end
      has_par = !fmt_par[2];
      case (fmt_par[1:0])
         PAR_EVEN: par_bit = ^masked;
         PAR_ODD:  par_bit = ~^masked;
         PAR_ZERO: par_bit = 1'b0;
         default:  par_bit = 1'b1;
      endcase
      if (has_par) begin
         body[pos] = par_bit;
         pos       = pos + 1;
      end
      pos      = pos + ((fmt_stop != 2'b00) ? 2 : 1);
      body_len = CNT_W'(pos);
   end

   assign start = bit_tick && tx_on && !brk_act && !q_empty &&
                  (!busy || left_q == '0);
   assign pop   = start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         line   <= 1'b1;
         sh_q   <= '1;
         left_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         line   <= 1'b0;
         sh_q   <= body;
         left_q <= body_len;
      end else if (bit_tick && busy) begin
         if (left_q == '0) begin
            busy <= 1'b0;
            line <= 1'b1;
         end else begin
            line   <= sh_q[0];
            sh_q   <= {1'b1, sh_q[BODY_W-1:1]};
            left_q <= left_q - 1'b1;
         end
      end
   end

   AST_START_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tx_on));                     // R5
   AST_NO_START_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(brk_act));                  // R7
   AST_HOLD_MIDBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_tick) |=> $stable(line));            // R4

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int DATA_W = 8,
   parameter int QDEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        fmt_len,
   input  logic [2:0]        fmt_par,
   input  logic [1:0]        fmt_stop,
   input  logic              ctl_en,
   input  logic              ctl_dis,
   input  logic              ctl_brk_on,
   input  logic              ctl_brk_off,
   input  logic              bit_tick,
   output logic              txd,
   output logic              tx_active,
   output logic              tx_empty
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("uart_frame_tx: DATA_W must be 8 to cover all length codes");
      end
      if (QDEPTH < 1) begin : g_bad_depth
         $error("uart_frame_tx: QDEPTH must be at least 1");
      end
   endgenerate

   logic              q_full, q_empty, q_pop;
   logic [DATA_W-1:0] q_head;
   logic              tx_on, brk_act, line;

   assign in_ready = !q_full;
   assign tx_empty = q_empty;

   uart_ftx_queue #(.DATA_W(DATA_W), .QDEPTH(QDEPTH)) queue_i (
      .clk(clk), .rst_n(rst_n),
      .push(in_valid && !q_full), .push_data(in_data),
      .pop(q_pop), .head(q_head), .full(q_full), .empty(q_empty)
   );

   uart_ftx_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_en(ctl_en), .ctl_dis(ctl_dis),
      .ctl_brk_on(ctl_brk_on), .ctl_brk_off(ctl_brk_off),
      .tx_on(tx_on), .brk_act(brk_act)
   );

   uart_ftx_shift #(.DATA_W(DATA_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
      .tx_on(tx_on), .brk_act(brk_act),
      .q_empty(q_empty), .q_head(q_head),
      .fmt_len(fmt_len), .fmt_par(fmt_par), .fmt_stop(fmt_stop),
      .pop(q_pop), .busy(tx_active), .line(line)
   );

   assign txd = brk_act ? 1'b0 : line;

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_active && !brk_act) |-> txd);                 // R4
   AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_brk_on && !ctl_brk_off) |=> !txd);            // R7

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
   localparam int DIV    = 8;
   localparam int QDEPTH = 2;

   typedef struct {
      logic [7:0] data;
      logic [1:0] len;
      logic [2:0] par;
      logic [1:0] stop;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [1:0] fmt_len = '0;
   logic [2:0] fmt_par = 3'b100;
   logic [1:0] fmt_stop = '0;
   logic       ctl_en = 0, ctl_dis = 0, ctl_brk_on = 0, ctl_brk_off = 0;
   logic       bit_tick = 1'b0;
   logic       txd, tx_active, tx_empty;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;
   bit mon_on = 1;
   item_t sb[$];

   always #5 clk = ~clk;

   uart_frame_tx #(.DATA_W(8), .QDEPTH(QDEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .fmt_len(fmt_len), .fmt_par(fmt_par),
      .fmt_stop(fmt_stop), .ctl_en(ctl_en), .ctl_dis(ctl_dis),
      .ctl_brk_on(ctl_brk_on), .ctl_brk_off(ctl_brk_off),
      .bit_tick(bit_tick), .txd(txd), .tx_active(tx_active),
      .tx_empty(tx_empty)
   );

   // Bit-rate enable: one cycle in every DIV.
   int tick_cnt = 0;
   always @(negedge clk) begin
      tick_cnt = (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;
      bit_tick = (tick_cnt == DIV - 1);
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   // Driver: offer one character and record the format in force.
   task automatic send(input logic [7:0] d);
      item_t it;
      it.data = d; it.len = fmt_len; it.par = fmt_par; it.stop = fmt_stop;
      sb.push_back(it);
      @(negedge clk);
      in_data = d;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ctl_en = 1;
         1: ctl_dis = 1;
         2: begin ctl_en = 1; ctl_dis = 1; end
         3: ctl_brk_on = 1;
         4: ctl_brk_off = 1;
         default: begin ctl_brk_on = 1; ctl_brk_off = 1; end
      endcase
      @(negedge clk);
      ctl_en = 0; ctl_dis = 0; ctl_brk_on = 0; ctl_brk_off = 0;
   endtask

   task automatic drain();
      while (sb.size() != 0 || tx_active || !tx_empty) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // Monitor: decode frames from txd and compare with the scoreboard.
   task automatic decode();
      item_t it;
      logic [7:0] got, msk;
      int nd, nst;
      logic pexp;
      repeat (DIV / 2) @(negedge clk);
      check(txd == 1'b0, "R4 start bit", txd, 0);
      check(tx_active == 1'b1, "R9 active in frame", tx_active, 1);
      if (sb.size() == 0) begin
         check(0, "R4 unexpected frame", 0, 1);
         return;
      end
      it = sb.pop_front();
      nd = (it.len == 2'b11) ? 6 : (it.len == 2'b10) ? 7 : 8;
      msk = 8'hFF >> (8 - nd);
      got = '0;
      for (int i = 0; i < nd; i++) begin
         repeat (DIV) @(negedge clk);
         got[i] = txd;
      end
      check(got == (it.data & msk), "R1 data bits LSB first", got, it.data & msk);
      if (!it.par[2]) begin
         repeat (DIV) @(negedge clk);
         case (it.par[1:0])
            2'b00:   pexp = ^(it.data & msk);
            2'b01:   pexp = ~^(it.data & msk);
            2'b10:   pexp = 1'b0;
            default: pexp = 1'b1;
         endcase
         check(txd == pexp, "R2 parity bit", txd, pexp);
      end
      nst = (it.stop != 2'b00) ? 2 : 1;
      for (int s = 0; s < nst; s++) begin
         repeat (DIV) @(negedge clk);
         check(txd == 1'b1, "R3 stop bit", txd, 1);
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (mon_on && txd === 1'b0) decode();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(txd == 1'b1, "R4 reset idle high", txd, 1);
      check(tx_active == 1'b0, "R9 reset inactive", tx_active, 0);
      check(tx_empty == 1'b1, "R9 reset empty", tx_empty, 1);
      check(in_ready == 1'b1, "R10 reset ready", in_ready, 1);

      // R5 off after reset; R10 fill the queue while off.
      fmt_len = 2'b00; fmt_par = 3'b100; fmt_stop = 2'b00;
      send(8'hA5);
      send(8'h3C);
      @(negedge clk);
      check(in_ready == 1'b0, "R10 ready low when full", in_ready, 0);
      repeat (5 * DIV) @(negedge clk);
      check(tx_active == 1'b0 && txd == 1'b1, "R5 no frame while off", tx_active, 0);
      check(tx_empty == 1'b0, "R9 queue not empty", tx_empty, 0);
      pulse(0);
      drain();
      check(tx_empty == 1'b1 && !tx_active, "R9 empty after drain", tx_empty, 1);

      // R1 R2 R3 every format combination, two characters each.
      for (int l = 0; l < 3; l++) begin
         for (int p = 0; p < 5; p++) begin
            for (int s = 0; s < 2; s++) begin
               fmt_len  = (l == 0) ? 2'b00 : (l == 1) ? 2'b10 : 2'b11;
               fmt_par  = (p == 4) ? 3'b100 : 3'(p);
               fmt_stop = s ? 2'b10 : 2'b00;
               send(8'(8'h5B + l * 37 + p * 11 + s * 5));
               send(8'(8'hC4 ^ (l * 19 + p * 7 + s)));
               drain();
            end
         end
      end

      // R8 format change in mid-frame does not affect that frame.
      fmt_len = 2'b00; fmt_par = 3'b000; fmt_stop = 2'b10;
      send(8'h81);
      while (!tx_active) @(negedge clk);
      fmt_len = 2'b11; fmt_par = 3'b100; fmt_stop = 2'b00;
      drain();
      send(8'h2D);      // R8 new format applies to the next frame
      drain();

      // R5 plain disable holds queued data.
      pulse(1);
      send(8'h66);
      repeat (4 * DIV) @(negedge clk);
      check(!tx_active && txd, "R5 disabled holds data", tx_active, 0);
      pulse(0);
      drain();

      // R6 enable and disable together leave it off.
      pulse(2);
      send(8'h99);
      repeat (4 * DIV) @(negedge clk);
      check(!tx_active && !tx_empty, "R6 disable wins", tx_active, 0);
      pulse(0);
      drain();

      // R7 break holds the line low and blocks frames.
      mon_on = 0;
      pulse(3);
      send(8'h17);
      for (int i = 0; i < 4 * DIV; i++) begin
         @(negedge clk);
         if (txd !== 1'b0 || tx_active) begin
            check(0, "R7 break low", txd, 0);
            break;
         end
      end
      check(txd == 1'b0 && !tx_empty, "R7 break held, data queued", txd, 0);
      @(negedge clk);
      ctl_brk_off = 1;
      @(negedge clk);
      ctl_brk_off = 0;
      check(txd == 1'b1, "R7 stop-break returns high", txd, 1);
      mon_on = 1;
      drain();

      // R7 both break pulses together: no break.
      pulse(5);
      check(txd == 1'b1, "R7 stop-break wins", txd, 1);
      repeat (DIV) @(negedge clk);
      check(txd == 1'b1, "R7 line stays high", txd, 1);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule